// File: doc/BRIEF.md
# Set-On-Less-Than Compare Unit

This block executes the four set-on-less-than compare instructions of a 32-bit load/store processor. It takes the fetched instruction word together with the two source register values that the register file has already read, and one clock edge later it presents a result that is either 1 or 0, the index of the register to be written, a write-enable and a flag that marks the instruction as a compare. Writing the result back to the register file and every other arithmetic operation belong to other blocks.

Two of the instructions use the register-register format: the second operand is the rt register value and the result goes to the register named by the rd field. The other two use the immediate format: the second operand is the 16-bit immediate, always sign-extended, and the result goes to the register named by the rt field. Signed and unsigned forms share one magnitude comparator. A signed compare is turned into an unsigned one by inverting the sign bit of both operands, so the unsigned-immediate form compares a sign-extended immediate as an unsigned number.

Top module: `slt_unit`

## Requirements
- R1: While rst_n is low, res_o, dst_o, wr_en_o and is_cmp_o are all zero, whatever the inputs are.
- R2: An instruction with opcode bits [31:26] = 0 and funct bits [5:0] = 42 (signed register compare) yields res_o = 1 when rs_val < rt_val as two's-complement numbers and 0 otherwise, with dst_o = instruction bits [15:11].
- R3: Opcode 0 with funct 43 (unsigned register compare) yields res_o = 1 when rs_val < rt_val as unsigned numbers and 0 otherwise, with dst_o = bits [15:11]; rs_val = 0xFFFFFFFF against rt_val = 0x00000001 gives 1 under R2 and 0 here.
- R4: Opcode 10 (signed immediate compare) compares rs_val with the sign-extended bits [15:0] as two's-complement numbers, with dst_o = bits [20:16]; rt_val has no effect on the result.
- R5: Opcode 11 (unsigned immediate compare) sign-extends bits [15:0] to 32 bits and then compares rs_val with it as unsigned numbers, with dst_o = bits [20:16]; rt_val has no effect.
- R6: res_o bits [31:1] are always zero; the result appears on the outputs at the first rising clock edge after the inputs are presented and stays there until the next edge.
- R7: For any other instruction (opcode 0 with another funct, or any other opcode) wr_en_o and is_cmp_o are 0, and res_o and dst_o are 0.
- R8: Equal operands give res_o = 0 in all four compare forms.
- R9: For every compare instruction wr_en_o and is_cmp_o are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | XLEN | Value of the first source register |
| rt_val | input | XLEN | Value of the second source register |
| res_o | output | XLEN | Compare result, 1 or 0 zero-extended |
| dst_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-enable for the destination register |
| is_cmp_o | output | 1 | Marks the registered instruction as a compare |

## Verification
The outputs are registered directly from the decode and compare logic, so a wrong internal state shows up on the very next edge: a bad sign-bias shows as an inverted res_o only when the operands differ in their top bit, a bad operand select shows as a dependence of res_o on rt_val for immediate forms, and a bad destination select shows as dst_o taken from the wrong field. The vectors are therefore chosen so that signed and unsigned answers disagree, so that zero-extension and sign-extension of the immediate disagree, and so that rt_val differs from the immediate; each of these faults flips the one-cycle result of at least one vector.

// File: rtl/slt_pkg.sv
package slt_pkg;

  localparam int ILEN   = 32;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;

  // field positions used by the decode
  localparam int OP_LSB = ILEN - OP_W;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OP_W-1:0] OPC_LTI   = 6'd10;
  localparam logic [OP_W-1:0] OPC_LTIU  = 6'd11;
  localparam logic [FN_W-1:0] FN_LT     = 6'd42;
  localparam logic [FN_W-1:0] FN_LTU    = 6'd43;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_LT   = 3'd1,
    K_LTU  = 3'd2,
    K_LTI  = 3'd3,
    K_LTIU = 3'd4
  } cmp_kind_e;

  typedef struct packed {
    cmp_kind_e kind;
    logic      is_cmp;
    logic      use_imm;
    logic      signed_cmp;
  } cmp_ctl_t;

endpackage

// File: rtl/slt_decode.sv
module slt_decode
  import slt_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output cmp_ctl_t        ctl
);

  function automatic cmp_kind_e classify(input logic [OP_W-1:0] op,
                                         input logic [FN_W-1:0] fn);
    cmp_kind_e k;
    k = K_NONE;
    if (op == OPC_REG) begin
      if (fn == FN_LT)       k = K_LT;
      else if (fn == FN_LTU) k = K_LTU;
    end else if (op == OPC_LTI) begin
      k = K_LTI;
    end else if (op == OPC_LTIU) begin
      k = K_LTIU;
    end
    return k;
  endfunction

  cmp_kind_e kind_w;

  always_comb begin
    kind_w         = classify(opcode, funct);
    ctl.kind       = kind_w;
    ctl.is_cmp     = (kind_w != K_NONE);
    ctl.use_imm    = (kind_w == K_LTI) || (kind_w == K_LTIU);
    ctl.signed_cmp = (kind_w == K_LT)  || (kind_w == K_LTI);
  end

endmodule

// File: rtl/slt_operand.sv
module slt_operand #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rt_val,
  input  logic             use_imm,
  output logic [XLEN-1:0]  opb
);

  logic [XLEN-1:0] imm_ext;

  generate
    if (IMM_W >= XLEN) begin : g_trunc
      assign imm_ext = imm[XLEN-1:0];
    end else begin : g_sext
      localparam int PAD = XLEN - IMM_W;
      assign imm_ext = {{PAD{imm[IMM_W-1]}}, imm};
    end
  endgenerate

  assign opb = use_imm ? imm_ext : rt_val;

endmodule

// File: rtl/slt_compare.sv
module slt_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            signed_cmp,
  output logic            lt
);

  localparam int MSB = XLEN - 1;

  // Inverting the top bit maps two's-complement order onto unsigned order,
  // so one magnitude comparator serves both forms.
  function automatic logic [XLEN-1:0] bias(input logic [XLEN-1:0] v,
                                           input logic s);
    logic [XLEN-1:0] r;
    r      = v;
    r[MSB] = v[MSB] ^ s;
    return r;
  endfunction

  logic [XLEN-1:0] a_b;
  logic [XLEN-1:0] b_b;

  assign a_b = bias(a, signed_cmp);
  assign b_b = bias(b, signed_cmp);
  assign lt  = (a_b < b_b);

endmodule

// File: rtl/slt_unit.sv
module slt_unit
  import slt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ILEN-1:0]     instr,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rt_val,
  output logic [XLEN-1:0]     res_o,
  output logic [RIDX_W-1:0]   dst_o,
  output logic                wr_en_o,
  output logic                is_cmp_o
);

  // instruction fields
  logic [OP_W-1:0]   f_op;
  logic [FN_W-1:0]   f_fn;
  logic [RIDX_W-1:0] f_rt;
  logic [RIDX_W-1:0] f_rd;
  logic [IMM_W-1:0]  f_imm;
  logic              unused_fields;

  assign f_op  = instr[ILEN-1:OP_LSB];
  assign f_fn  = instr[FN_W-1:0];
  assign f_rt  = instr[RT_LSB +: RIDX_W];
  assign f_rd  = instr[RD_LSB +: RIDX_W];
  assign f_imm = instr[IMM_W-1:0];
  assign unused_fields = ^instr[25:21];

  // named internal events
  cmp_ctl_t          ctl;
  logic [XLEN-1:0]   opb;
  logic              lt_w;
  logic [RIDX_W-1:0] dst_w;
  logic [XLEN-1:0]   res_w;

  slt_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl)
  );

  slt_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opb (
    .imm     (f_imm),
    .rt_val  (rt_val),
    .use_imm (ctl.use_imm),
    .opb     (opb)
  );

  slt_compare #(.XLEN(XLEN)) u_cmp (
    .a          (rs_val),
    .b          (opb),
    .signed_cmp (ctl.signed_cmp),
    .lt         (lt_w)
  );

  always_comb begin
    dst_w = '0;
    res_w = '0;
    if (ctl.is_cmp) begin
      dst_w    = ctl.use_imm ? f_rt : f_rd;
      res_w[0] = lt_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o    <= '0;
      dst_o    <= '0;
      wr_en_o  <= 1'b0;
      is_cmp_o <= 1'b0;
    end else begin
      res_o    <= res_w;
      dst_o    <= dst_w;
      wr_en_o  <= ctl.is_cmp;
      is_cmp_o <= ctl.is_cmp;
    end
  end

endmodule

// File: rtl/slt_unit_chk.sv
module slt_unit_chk
  import slt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ILEN-1:0]   instr,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   rt_val,
  input logic [XLEN-1:0]   res_o,
  input logic [RIDX_W-1:0] dst_o,
  input logic              wr_en_o,
  input logic              is_cmp_o
);

  logic is_lt, is_ltu, is_lti, is_ltiu;
  logic [XLEN-1:0] imm_sx;

  assign is_lt   = (instr[31:26] == 6'd0)  && (instr[5:0] == 6'd42);
  assign is_ltu  = (instr[31:26] == 6'd0)  && (instr[5:0] == 6'd43);
  assign is_lti  = (instr[31:26] == 6'd10);
  assign is_ltiu = (instr[31:26] == 6'd11);
  assign imm_sx  = XLEN'($signed(instr[15:0]));

  // R2
  p_signed_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_lt |=> (res_o[0] == ($signed($past(rs_val)) < $signed($past(rt_val))))
              && (dst_o == $past(instr[15:11])));

  // R3
  p_unsigned_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_ltu |=> (res_o[0] == ($past(rs_val) < $past(rt_val)))
               && (dst_o == $past(instr[15:11])));

  // R4
  p_signed_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_lti |=> (res_o[0] == ($signed($past(rs_val)) < $signed($past(imm_sx))))
               && (dst_o == $past(instr[20:16])));

  // R5
  p_unsigned_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ltiu |=> (res_o[0] == ($past(rs_val) < $past(imm_sx)))
                && (dst_o == $past(instr[20:16])));

  // R6
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_o[XLEN-1:1] == '0);

  // R7
  p_quiet_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_lt || is_ltu || is_lti || is_ltiu) |=>
      !wr_en_o && !is_cmp_o && (res_o == '0) && (dst_o == '0));

  // R9
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lt || is_ltu || is_lti || is_ltiu) |=> wr_en_o && is_cmp_o);

endmodule

bind slt_unit slt_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .res_o    (res_o),
  .dst_o    (dst_o),
  .wr_en_o  (wr_en_o),
  .is_cmp_o (is_cmp_o)
);

// File: tb/test_slt_unit.sv
`timescale 1ns/1ps
module test_slt_unit;

  localparam int N = 16;

  function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, 5'd3, 5'd4, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [15:0] imm);
    return {op, 5'd2, rt, imm};
  endfunction

  // stimulus and expected values, worked out by hand from the requirements
  localparam logic [31:0] V_INS [N] = '{
    enc_r(5'd5, 6'd42), enc_r(5'd6, 6'd43), enc_r(5'd7, 6'd42), enc_r(5'd8, 6'd43),
    enc_r(5'd9, 6'd42), enc_r(5'd10, 6'd42), enc_r(5'd11, 6'd43),
    enc_i(6'd10, 5'd12, 16'hFFFF), enc_i(6'd10, 5'd13, 16'h8000),
    enc_i(6'd11, 5'd14, 16'hFFFF), enc_i(6'd11, 5'd15, 16'hFFFF),
    enc_i(6'd11, 5'd16, 16'hFFFF), enc_i(6'd10, 5'd17, 16'h7FFF),
    enc_r(5'd18, 6'd32), enc_i(6'd8, 5'd19, 16'h0001), enc_i(6'd12, 5'd20, 16'hFFFF)
  };
  localparam logic [31:0] V_RS [N] = '{
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h80000000,
    32'h7FFFFFFF, 32'h12345678, 32'h89ABCDEF,
    32'hFFFFFFFE, 32'h00000005, 32'h00000005, 32'hFFFFFFFF,
    32'h0000FFFF, 32'h00007FFF, 32'h00000001, 32'h00000000, 32'h00000000
  };
  localparam logic [31:0] V_RT [N] = '{
    32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'h7FFFFFFF,
    32'h80000000, 32'h12345678, 32'h89ABCDEF,
    32'h80000000, 32'h00000000, 32'h00000000, 32'h00000000,
    32'h00000000, 32'hFFFFFFFF, 32'h00000005, 32'h00000005, 32'h00000005
  };
  localparam logic V_RES [N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                 1'b0, 1'b0, 1'b0};
  localparam logic [4:0] V_DST [N] = '{5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11,
                                       5'd12, 5'd13, 5'd14, 5'd15, 5'd16, 5'd17,
                                       5'd0, 5'd0, 5'd0};
  localparam logic V_WE [N] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                1'b0, 1'b0, 1'b0};
  localparam string V_TAG [N] = '{"R2", "R3", "R2", "R3", "R2", "R8", "R8",
                                  "R4", "R4", "R5", "R8", "R5", "R8",
                                  "R7", "R7", "R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] res_o;
  logic [4:0]  dst_o;
  logic        wr_en_o;
  logic        is_cmp_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  slt_unit i_slt_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .res_o    (res_o),
    .dst_o    (dst_o),
    .wr_en_o  (wr_en_o),
    .is_cmp_o (is_cmp_o)
  );

  task automatic check(input string tag, input logic [31:0] e_res,
                       input logic [4:0] e_dst, input logic e_we);
    total++;
    if (res_o !== e_res || dst_o !== e_dst || wr_en_o !== e_we || is_cmp_o !== e_we) begin
      bad++;
      $display("FAIL %s: res=%h dst=%0d we=%b cmp=%b expected res=%h dst=%0d we=%b cmp=%b",
               tag, res_o, dst_o, wr_en_o, is_cmp_o, e_res, e_dst, e_we, e_we);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr  = i;
    rs_val = a;
    rt_val = b;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: reset holds outputs at zero even with a compare on the inputs
    instr  = enc_r(5'd5, 6'd42);
    rs_val = 32'hFFFFFFFF;
    rt_val = 32'h00000001;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'd0, 5'd0, 1'b0);
    rst_n = 1'b1;

    // vector table
    for (int k = 0; k < N; k++) begin
      apply(V_INS[k], V_RS[k], V_RT[k]);
      check(V_TAG[k], {31'd0, V_RES[k]}, V_DST[k], V_WE[k]);
    end

    // R4: rt_val has no effect on the signed immediate form
    apply(enc_i(6'd10, 5'd21, 16'h0010), 32'h0000000F, 32'h00000000);
    check("R4 rt_val ignored", 32'd1, 5'd21, 1'b1);
    // R5: rt_val has no effect on the unsigned immediate form
    apply(enc_i(6'd11, 5'd22, 16'h0001), 32'h00000002, 32'hFFFFFFFF);
    check("R5 rt_val ignored", 32'd0, 5'd22, 1'b1);

    // R6: result held until the next edge, then updated one cycle later
    @(negedge clk);
    instr  = enc_r(5'd23, 6'd43);
    rs_val = 32'h00000000;
    rt_val = 32'h00000001;
    #1;
    check("R6 held before edge", 32'd0, 5'd22, 1'b1);
    @(negedge clk);
    check("R6 after edge", 32'd1, 5'd23, 1'b1);

    // R9 and R2: zero-index destination still flagged as a write
    apply(enc_r(5'd0, 6'd42), 32'h80000000, 32'h00000000);
    check("R9 rd zero", 32'd1, 5'd0, 1'b1);

    // R1: asynchronous reset clears a live result
    apply(enc_r(5'd24, 6'd42), 32'hFFFFFFFF, 32'h00000000);
    check("R2 before reset", 32'd1, 5'd24, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset", 32'd0, 5'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(enc_i(6'd11, 5'd25, 16'h8000), 32'h7FFFFFFF, 32'h0);
    check("R5 after reset", 32'd1, 5'd25, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule